// File: doc/BRIEF.md
# Bang-bang clock and data recovery phase controller

This block is the digital heart of an interpolator-based clock and data recovery receiver. Every unit interval an external pair of samplers hands it one bit taken at the data phase and one bit taken at the edge phase. It keeps a single phase accumulator from which two interpolator codes are formed: the edge code and the data code, which always sit exactly half a unit interval apart. Whenever two consecutive data bits differ, the edge bit between them says whether the edge sampler fired before or after the line transition. Those early/late votes pass through a proportional counter and an integral frequency register. Both codes then shift so that the edge sampler sits on the transitions and the data sampler lands in the middle of each bit.

The recovered bits leave as a stream one cycle after each accepted sample. The sample stream has a valid qualifier but no ready: a physical sampler cannot be stalled, so every sample with `in_valid` high is consumed in the cycle it is presented. Downstream logic must take every `rx_valid` beat, because no back-pressure exists. A lock flag reports, once per window of transitions, whether the loop is still being dragged in one direction.

Phase codes are 7 bits, so one unit interval spans 128 steps, and a larger code means a later sampling instant. The synchronous reset is active high.

Top module: `cdr_phase_ctrl`

## Requirements
- R1: After reset, `edge_code` is 0, `data_code` is 64, `locked` is 0 and `rx_valid` is 0, and the vote counter and the frequency register are zero.
- R2: `data_code` always equals `edge_code` plus 64 modulo 128. Both codes wrap modulo 128, so stepping down from 0 gives 127 and 63.
- R3: A vote is cast only for an accepted sample whose data bit differs from the data bit of the previous accepted sample. The first accepted sample after reset casts no vote. Cycles with `in_valid` low change no state and leave the codes unchanged.
- R4: On a transition, an edge bit equal to the previous data bit is a retard vote (+1, move later). An edge bit equal to the new data bit is an advance vote (-1, move earlier).
- R5: Votes are summed in a signed counter. When a vote brings it to +8, `edge_code` rises by one, and the change is visible on the cycle after that sample. When a vote brings it to -8, the code falls by one. In both cases the counter returns to 0. Opposite votes cancel.
- R6: Each proportional step adds +1 or -1 to a frequency register that saturates at ±511. On every accepted sample that register is added to a 12-bit fraction held below the code. A carry out of that fraction moves the code by one.
- R7: `rx_valid` is `in_valid` delayed by one cycle, and `rx_bit` is the data bit of that sample. There is no back-pressure.
- R8: Transitions are counted in windows of 256. A proportional step in the same direction as the previous step counts as a repeat. On the last transition of a window, `locked` becomes 1 if the window held at most 4 repeats, otherwise 0. It changes at no other time.
- R9: Driven by a transmitter offset of 0 or ±200 ppm with small jitter, the loop asserts `locked` within 20000 samples. After that, every recovered bit equals the transmitted bit, consecutive samples take consecutive transmitted bits, and each data sample lies within the middle half of its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle at most |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair present this cycle |
| data_bit | input | 1 | Bit taken at the data phase |
| edge_bit | input | 1 | Bit taken at the edge phase, between previous and current data bits |
| rx_valid | output | 1 | Recovered bit valid |
| rx_bit | output | 1 | Recovered data bit |
| edge_code | output | 7 | Edge interpolator code |
| data_code | output | 7 | Data interpolator code |
| locked | output | 1 | Loop lock indication |

## Verification
Every result is due one cycle after the sample that causes it. This covers the recovered bit, a code step after the eighth like vote, an integral carry and the lock update at the 256th transition. The bench drives inputs on the falling edge and reads outputs on the next falling edge, after exactly one rising edge. For directed checks it first idles `in_valid`, so the state holds still while it is read. In the tracking runs, each recovered bit is compared one falling edge after its sample was driven. The comparison uses the bit the transmitter model placed at the jitter-free data instant computed from the codes the block showed when the sample was taken.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [1:0] {
    VOTE_NONE    = 2'd0,
    VOTE_RETARD  = 2'd1,
    VOTE_ADVANCE = 2'd2
  } vote_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/cdr_edge_vote.sv
module cdr_edge_vote
  import cdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  logic  data_bit,
  input  logic  edge_bit,
  output vote_e vote,
  output logic  rx_valid,
  output logic  rx_bit
);
  logic have_prev_q;
  logic prev_bit_q;

  always_comb begin
    vote = VOTE_NONE;
    if (in_valid && have_prev_q && (data_bit != prev_bit_q)) begin
      if (edge_bit == prev_bit_q) vote = VOTE_RETARD;
      else                        vote = VOTE_ADVANCE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev_q <= 1'b0;
      prev_bit_q  <= 1'b0;
      rx_valid    <= 1'b0;
      rx_bit      <= 1'b0;
    end else begin
      rx_valid <= in_valid;
      if (in_valid) begin
        have_prev_q <= 1'b1;
        prev_bit_q  <= data_bit;
        rx_bit      <= data_bit;
      end
    end
  end

  assert_rx_follow_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (rx_valid && (rx_bit == $past(data_bit))));
  assert_rx_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !rx_valid);
endmodule

// File: rtl/cdr_loop_filter.sv
module cdr_loop_filter
  import cdr_pkg::*;
#(
  parameter int THRESH = 8,
  parameter int F_W    = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  vote_e                 vote,
  output step_e                 step,
  output logic signed [F_W-1:0] freq
);
  localparam int CNT_W = $clog2(THRESH) + 2;
  localparam logic signed [CNT_W-1:0] POS_LIM = CNT_W'(THRESH);
  localparam logic signed [CNT_W-1:0] NEG_LIM = CNT_W'(-THRESH);
  localparam logic signed [F_W-1:0] F_MAX = F_W'((1 << (F_W - 1)) - 1);
  localparam logic signed [F_W-1:0] F_MIN = F_W'(-((1 << (F_W - 1)) - 1));

  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] cnt_sum;
  logic signed [F_W-1:0]   freq_q;

  always_comb begin
    unique case (vote)
      VOTE_RETARD:  cnt_sum = cnt_q + CNT_W'(1);
      VOTE_ADVANCE: cnt_sum = cnt_q - CNT_W'(1);
      default:      cnt_sum = cnt_q;
    endcase
    if (cnt_sum == POS_LIM)      step = STEP_UP;
    else if (cnt_sum == NEG_LIM) step = STEP_DN;
    else                         step = STEP_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      freq_q <= '0;
    end else begin
      if (step != STEP_NONE) cnt_q <= '0;
      else                   cnt_q <= cnt_sum;
      if ((step == STEP_UP) && (freq_q != F_MAX))
        freq_q <= freq_q + F_W'(1);
      else if ((step == STEP_DN) && (freq_q != F_MIN))
        freq_q <= freq_q - F_W'(1);
    end
  end

  assign freq = freq_q;

  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (vote == VOTE_NONE) |=> $stable(cnt_q));
  assert_cnt_window_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < POS_LIM) && (cnt_q > NEG_LIM));
  assert_step_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_NONE) |=> (cnt_q == '0));
  assert_freq_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (freq_q <= F_MAX) && (freq_q >= F_MIN));
endmodule

// File: rtl/cdr_phase_accum.sv
module cdr_phase_accum
  import cdr_pkg::*;
#(
  parameter int PH_W   = 7,
  parameter int FRAC_W = 12,
  parameter int F_W    = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  step_e                 step,
  input  logic signed [F_W-1:0] freq,
  output logic [PH_W-1:0]       edge_code,
  output logic [PH_W-1:0]       data_code
);
  localparam int ACC_W = PH_W + FRAC_W;
  localparam logic [ACC_W-1:0] ONE_STEP = ACC_W'(1) << FRAC_W;
  localparam logic [PH_W-1:0]  HALF_UI  = PH_W'(1) << (PH_W - 1);

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W-1:0] freq_ext;
  logic [ACC_W-1:0] step_term;

  assign freq_ext = {{(ACC_W - F_W){freq[F_W-1]}}, freq};

  always_comb begin
    unique case (step)
      STEP_UP: step_term = ONE_STEP;
      STEP_DN: step_term = (~ONE_STEP) + ACC_W'(1);
      default: step_term = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           phase_q <= '0;
    else if (in_valid) phase_q <= phase_q + freq_ext + step_term;
  end

  assign edge_code = phase_q[ACC_W-1 -: PH_W];
  assign data_code = edge_code + HALF_UI;

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/cdr_lock_mon.sv
module cdr_lock_mon
  import cdr_pkg::*;
#(
  parameter int LOCK_WIN = 256,
  parameter int LOCK_MAX = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  vote_e vote,
  input  step_e step,
  output logic  locked
);
  localparam int WIN_W = $clog2(LOCK_WIN);
  localparam int REP_W = $clog2(LOCK_WIN) + 1;

  logic [WIN_W-1:0] win_cnt_q;
  logic [REP_W-1:0] rep_cnt_q;
  logic [REP_W-1:0] rep_total;
  step_e            last_dir_q;
  logic             vote_seen;
  logic             is_rep;
  logic             win_end;
  logic             locked_q;

  assign vote_seen = (vote != VOTE_NONE);
  assign is_rep    = (step != STEP_NONE) && (step == last_dir_q);
  assign rep_total = rep_cnt_q + REP_W'(is_rep);
  assign win_end   = vote_seen && (win_cnt_q == WIN_W'(LOCK_WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt_q  <= '0;
      rep_cnt_q  <= '0;
      last_dir_q <= STEP_NONE;
      locked_q   <= 1'b0;
    end else begin
      if (step != STEP_NONE) last_dir_q <= step;
      if (vote_seen) begin
        if (win_end) begin
          win_cnt_q <= '0;
          rep_cnt_q <= '0;
          locked_q  <= (rep_total <= REP_W'(LOCK_MAX));
        end else begin
          win_cnt_q <= win_cnt_q + WIN_W'(1);
          rep_cnt_q <= rep_total;
        end
      end
    end
  end

  assign locked = locked_q;

  assert_lock_at_window_R8: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(locked_q));
  assert_step_needs_vote_R5: assert property (@(posedge clk) disable iff (rst)
    (step != STEP_NONE) |-> vote_seen);
endmodule

// File: rtl/cdr_phase_ctrl.sv
module cdr_phase_ctrl
  import cdr_pkg::*;
#(
  parameter int PH_W     = 7,
  parameter int FRAC_W   = 12,
  parameter int F_W      = 10,
  parameter int THRESH   = 8,
  parameter int LOCK_WIN = 256,
  parameter int LOCK_MAX = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            data_bit,
  input  logic            edge_bit,
  output logic            rx_valid,
  output logic            rx_bit,
  output logic [PH_W-1:0] edge_code,
  output logic [PH_W-1:0] data_code,
  output logic            locked
);
  vote_e                 vote;
  step_e                 step;
  logic signed [F_W-1:0] freq;

  cdr_edge_vote u_vote (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .data_bit (data_bit),
    .edge_bit (edge_bit),
    .vote     (vote),
    .rx_valid (rx_valid),
    .rx_bit   (rx_bit)
  );

  cdr_loop_filter #(.THRESH(THRESH), .F_W(F_W)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .vote (vote),
    .step (step),
    .freq (freq)
  );

  cdr_phase_accum #(.PH_W(PH_W), .FRAC_W(FRAC_W), .F_W(F_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .step      (step),
    .freq      (freq),
    .edge_code (edge_code),
    .data_code (data_code)
  );

  cdr_lock_mon #(.LOCK_WIN(LOCK_WIN), .LOCK_MAX(LOCK_MAX)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .vote   (vote),
    .step   (step),
    .locked (locked)
  );

  assert_offset_track_R2: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (PH_W'(data_code - $past(data_code)) == PH_W'(edge_code - $past(edge_code))));
  assert_code_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(edge_code));
endmodule

// File: tb/tb_cdr_phase_ctrl.sv
`timescale 1ns/1ps
module tb_cdr_phase_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, data_bit = 1'b0, edge_bit = 1'b0;
  logic rx_valid, rx_bit, locked;
  logic [6:0] edge_code, data_code;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  bit last_d;

  always #2 clk = ~clk;

  cdr_phase_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_bit(data_bit),
    .edge_bit(edge_bit), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .edge_code(edge_code), .data_code(data_code), .locked(locked)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit txbit(input longint k);
    longint x;
    x = k * 64'h9E3779B97F4A7C15;
    return x[40] ^ x[17] ^ x[61];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input bit v, input bit d, input bit e);
    @(negedge clk);
    in_valid = v; data_bit = d; edge_bit = e;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic init_stream();
    push(1'b1, 1'b0, 1'b0);
    last_d = 1'b0;
  endtask

  task automatic vote(input bit retard);
    bit nd;
    nd = ~last_d;
    push(1'b1, nd, retard ? last_d : nd);
    last_d = nd;
  endtask

  task automatic track(input int ppm, input string tag);
    longint ui, ttx, t0, te, tdn, kd, pos, pend_k, prev_k;
    int ph, delta, lock_at, chk_n, bad_bit, bad_mid, bad_seq, jit;
    logic [6:0] pcode;
    bit pend, pend_bit, have_prev_k;
    ui = 64'd1 << 20;
    ttx = ui + (ui * ppm) / 1000000;
    do_reset();
    t0 = longint'($urandom_range(0, 32'(ui - 1))) + 8 * ui;
    ph = 0; pcode = 7'd0; lock_at = -1; chk_n = 0;
    bad_bit = 0; bad_mid = 0; bad_seq = 0; pend = 1'b0; have_prev_k = 1'b0;
    pend_k = 0; prev_k = 0; pend_bit = 1'b0; pos = 0;
    for (int n = 0; n < 26000 && chk_n < 6000; n++) begin
      @(negedge clk);
      delta = int'(7'(edge_code - pcode));
      if (delta > 63) delta -= 128;
      ph += delta;
      pcode = edge_code;
      if (pend && lock_at >= 0) begin
        chk_n++;
        if (rx_bit !== pend_bit) bad_bit++;
        if (have_prev_k && pend_k != prev_k + 1) bad_seq++;
        prev_k = pend_k; have_prev_k = 1'b1;
      end
      if (locked && lock_at < 0) lock_at = n;
      if (lock_at < 0 && n >= 20000) break;
      te = longint'(n) * ui + t0 + longint'(ph) * (ui / 128);
      jit = int'($urandom_range(0, 4096)) - 2048;
      edge_bit = txbit((te + jit) / ttx);
      tdn = te + ui / 2;
      jit = int'($urandom_range(0, 4096)) - 2048;
      data_bit = txbit((tdn + jit) / ttx);
      in_valid = 1'b1;
      kd = tdn / ttx;
      pos = tdn - kd * ttx;
      if (lock_at >= 0 && (pos < ttx / 4 || pos > (3 * ttx) / 4)) bad_mid++;
      pend = 1'b1; pend_bit = txbit(kd); pend_k = kd;
    end
    settle();
    chk(lock_at >= 0, {"R9 lock reached ", tag}, lock_at, 20000);
    chk(bad_bit == 0 && chk_n > 1000, {"R9 recovered bits match ", tag}, bad_bit, 0);
    chk(bad_seq == 0, {"R9 no skipped or repeated bit ", tag}, bad_seq, 0);
    chk(bad_mid == 0, {"R9 data sample mid-bit ", tag}, bad_mid, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int bad;
    bit pv, pd;
    void'($urandom(32'd20240611));

    // R1 reset state
    do_reset();
    chk(edge_code == 7'd0, "R1 edge_code reset", edge_code, 0);
    chk(data_code == 7'd64, "R1 data_code reset", data_code, 64);
    chk(locked == 1'b0, "R1 locked reset", locked, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid reset", rx_valid, 0);

    // R3 no transition means no vote, edge bit ignored
    do_reset();
    for (int i = 0; i < 200; i++) push(1'b1, 1'b0, 1'($urandom_range(0, 1)));
    settle();
    chk(edge_code == 7'd0, "R3 constant data leaves code", edge_code, 0);

    // R3 samples with in_valid low are ignored
    do_reset();
    init_stream();
    for (int i = 0; i < 40; i++) push(1'b0, 1'(i), 1'b0);
    settle();
    chk(edge_code == 7'd0, "R3 invalid samples ignored", edge_code, 0);
    chk(rx_valid == 1'b0, "R3 rx_valid low while idle", rx_valid, 0);

    // R4 R5 retard votes: 7 hold, 8th steps up, first sample casts no vote
    do_reset();
    init_stream();
    for (int i = 0; i < 7; i++) vote(1'b1);
    settle();
    chk(edge_code == 7'd0, "R5 seven votes no step", edge_code, 0);
    vote(1'b1);
    settle();
    chk(edge_code == 7'd1, "R4 retard raises code", edge_code, 1);
    chk(data_code == 7'd65, "R2 data follows edge", data_code, 65);
    for (int i = 0; i < 7; i++) vote(1'b1);
    settle();
    chk(edge_code == 7'd1, "R5 counter cleared after step", edge_code, 1);
    vote(1'b1);
    settle();
    chk(edge_code == 7'd2, "R5 second step", edge_code, 2);

    // R2 R4 advance votes wrap below zero
    do_reset();
    init_stream();
    for (int i = 0; i < 8; i++) vote(1'b0);
    settle();
    chk(edge_code == 7'd127, "R2 edge wraps to 127", edge_code, 127);
    chk(data_code == 7'd63, "R2 data wraps to 63", data_code, 63);

    // R5 opposite votes cancel
    do_reset();
    init_stream();
    for (int i = 0; i < 60; i++) vote(1'(i % 2));
    settle();
    chk(edge_code == 7'd0, "R5 alternating votes cancel", edge_code, 0);

    // R6 integral carry after 4096 accepted samples at freq +1
    do_reset();
    init_stream();
    for (int i = 0; i < 8; i++) vote(1'b1);
    for (int i = 0; i < 4095; i++) push(1'b1, last_d, 1'b0);
    settle();
    chk(edge_code == 7'd1, "R6 no carry at 4095", edge_code, 1);
    push(1'b1, last_d, 1'b0);
    settle();
    chk(edge_code == 7'd2, "R6 carry at 4096", edge_code, 2);

    // R8 lock window
    do_reset();
    init_stream();
    for (int i = 0; i < 255; i++) vote(((i / 8) % 2) == 0);
    settle();
    chk(locked == 1'b0, "R8 no lock before window end", locked, 0);
    vote(1'b0);
    settle();
    chk(locked == 1'b1, "R8 lock at window end", locked, 1);
    for (int i = 0; i < 255; i++) vote(1'b1);
    settle();
    chk(locked == 1'b1, "R8 lock held mid-window", locked, 1);
    vote(1'b1);
    settle();
    chk(locked == 1'b0, "R8 repeats drop lock", locked, 0);

    // R7 random stream
    do_reset();
    bad = 0; pv = 1'b0; pd = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rx_valid !== pv || (pv && rx_bit !== pd)) bad++;
      pv = 1'($urandom_range(0, 3) != 0);
      pd = 1'($urandom_range(0, 1));
      in_valid = pv; data_bit = pd; edge_bit = 1'($urandom_range(0, 1));
    end
    settle();
    chk(bad == 0, "R7 rx stream follows input", bad, 0);

    // R9 tracking under offset and jitter
    track(0, "0ppm");
    track(200, "+200ppm");
    track(-200, "-200ppm");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule